// File: doc/BRIEF.md
# Cache Invalidate-All Sequencer

This block clears every set of a cache when software writes 1 to a self-clearing invalidate control bit. After the write, it steps an index through the tag array, one set per clock. On each step it raises a write enable together with two clear strobes, one for the valid bit and one for the modified bit of that set.

While the sweep runs, a stall output holds off all new data accesses. The control bit reads back as 1 for the same span. When the last set has been cleared, the bit returns to 0 and the stall drops in the same cycle, so software never clears the bit itself.

Reset only returns the sequencer to idle. It never touches the tag array, so cache contents survive a reset until a sweep is requested. Writing back dirty lines before a sweep is the caller's job.

Top module: `cache_inval_seq`

## Requirements
- R1: A register write with `cfg_wdata_i`=1 while idle starts a sweep: from the next cycle `stall_o`=1, `cfg_rdata_o`=1 and `tag_idx_o`=0.
- R2: A register write with `cfg_wdata_i`=0 has no effect: the block stays idle, with `stall_o`=0, `cfg_rdata_o`=0 and no tag write.
- R3: During a sweep, exactly one set is addressed per cycle, in ascending order from 0 to NUM_SETS-1. Each of these cycles has `tag_we_o`=1 and both `tag_clr_valid_o` and `tag_clr_mod_o` at 1. No tag write occurs outside a sweep.
- R4: `stall_o` is 1 in every cycle of the sweep, for exactly NUM_SETS cycles, up to and including the cycle that clears the last set.
- R5: `cfg_rdata_o` reads 1 throughout the sweep. It returns to 0 by itself in the cycle after the last set is cleared, and `stall_o` falls in that same cycle.
- R6: A write of 1 during a sweep is ignored: the index keeps counting and the sweep length stays NUM_SETS.
- R7: During and after reset, `stall_o`=0, `cfg_rdata_o`=0 and no tag write is issued, so reset leaves the cache contents unchanged.
- R8: After a sweep, the valid bit and the modified bit of every set are 0, whatever they held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write strobe for the invalidate control bit |
| cfg_wdata_i | input | 1 | Written value of the invalidate bit |
| cfg_rdata_o | output | 1 | Read-back of the invalidate bit, 1 while the sweep runs |
| tag_idx_o | output | IDX_W | Set index being cleared |
| tag_we_o | output | 1 | Tag array write enable |
| tag_clr_valid_o | output | 1 | Clear strobe for the valid bit of the indexed set |
| tag_clr_mod_o | output | 1 | Clear strobe for the modified bit of the indexed set |
| stall_o | output | 1 | Holds off data accesses during the sweep |

## Verification
The bench holds a bit-array model of the tag array and runs several patterns against it:
- **Full array.** A sweep over an array with every bit set shows that every set is reached once and in order.
- **Alternating contents.** A second sweep over alternating valid and modified contents shows that both strobes act on every set, whatever each set held before.
- **Write of 0.** An idle write of 0 separates a real trigger from a plain register write.
- **Write of 1 mid-sweep.** A write of 1 part-way through a sweep would show up as repeated indices or a longer stall if it restarted the sweep.
- **Reset.** A reset applied over populated contents shows that only a sweep clears the array.

// File: rtl/cis_pkg.sv
package cis_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } sweep_state_e;
endpackage

// File: rtl/cis_sweep_ctrl.sv
module cis_sweep_ctrl
  import cis_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic last_i,
  output logic busy_o,
  output logic start_o
);
  sweep_state_e state_q, state_d;

  assign busy_o  = (state_q == ST_SWEEP);
  // a trigger during a sweep is dropped
  assign start_o = trig_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_o) state_d = ST_SWEEP;
      ST_SWEEP: if (last_i)  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/cis_idx_counter.sv
module cis_idx_counter #(
  parameter int unsigned NUM_SETS = 512,
  localparam int unsigned IDX_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(NUM_SETS - 1);

  logic [IDX_W-1:0] idx_q;

  assign idx_o  = idx_q;
  assign last_o = en_i && (idx_q == LastIdx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (last_o) idx_q <= '0;
    else if (en_i)   idx_q <= idx_q + 1'b1;
  end
endmodule

// File: rtl/cache_inval_seq.sv
module cache_inval_seq #(
  parameter int unsigned NUM_SETS = 512,
  localparam int unsigned IDX_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_wdata_i,
  output logic             cfg_rdata_o,
  output logic [IDX_W-1:0] tag_idx_o,
  output logic             tag_we_o,
  output logic             tag_clr_valid_o,
  output logic             tag_clr_mod_o,
  output logic             stall_o
);
  logic busy, start, last;

  cis_sweep_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (cfg_we_i && cfg_wdata_i),
    .last_i  (last),
    .busy_o  (busy),
    .start_o (start)
  );

  cis_idx_counter #(.NUM_SETS(NUM_SETS)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .en_i   (busy),
    .idx_o  (tag_idx_o),
    .last_o (last)
  );

  assign cfg_rdata_o     = busy;
  assign stall_o         = busy;
  assign tag_we_o        = busy;
  assign tag_clr_valid_o = busy;
  assign tag_clr_mod_o   = busy;
endmodule

// File: rtl/cache_inval_seq_chk.sv
module cache_inval_seq_chk #(
  parameter int unsigned NUM_SETS = 512,
  localparam int unsigned IDX_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic             cfg_wdata_i,
  input logic             cfg_rdata_o,
  input logic [IDX_W-1:0] tag_idx_o,
  input logic             tag_we_o,
  input logic             tag_clr_valid_o,
  input logic             tag_clr_mod_o,
  input logic             stall_o
);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(NUM_SETS - 1);

  assert_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_wdata_i && !stall_o) |=> (stall_o && cfg_rdata_o && tag_idx_o == '0));

  assert_zero_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_wdata_i && !stall_o) |=> !stall_o);

  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_we_o && tag_idx_o != LastIdx) |=> (tag_we_o && tag_idx_o == $past(tag_idx_o) + 1'b1));

  assert_we_stalled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_we_o |-> (stall_o && tag_clr_valid_o && tag_clr_mod_o));

  assert_self_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_we_o && tag_idx_o == LastIdx) |=> (!cfg_rdata_o && !stall_o));

  assert_no_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && cfg_we_i && cfg_wdata_i && tag_idx_o != LastIdx) |=> (tag_idx_o != '0));

  assert_fall_at_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stall_o) |-> ($past(tag_idx_o) == LastIdx));

  always_comb begin
    if (!rst_ni) assert_reset_quiet_R7: assert (!tag_we_o && !stall_o && !cfg_rdata_o);
  end
endmodule

bind cache_inval_seq cache_inval_seq_chk #(.NUM_SETS(NUM_SETS)) i_chk (.*);

// File: tb/test_cache_inval_seq.sv
module test_cache_inval_seq;
  localparam int N = 512;
  localparam int IW = $clog2(N);
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_wdata = 0;
  logic cfg_rdata, tag_we, clr_v, clr_m, stall;
  logic [IW-1:0] tag_idx;

  logic [N-1:0] v_arr, m_arr;
  int exp_q[$];
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_inval_seq #(.NUM_SETS(N)) i_cache_inval_seq (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .tag_idx_o(tag_idx), .tag_we_o(tag_we),
    .tag_clr_valid_o(clr_v), .tag_clr_mod_o(clr_m), .stall_o(stall));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: expected index stream for one sweep
  task automatic push_sweep();
    for (int i = 0; i < N; i++) exp_q.push_back(i);
  endtask

  task automatic wr(input logic b);
    @(negedge clk); cfg_we = 1; cfg_wdata = b;
    @(negedge clk); cfg_we = 0; cfg_wdata = 0;
  endtask

  // monitor: a tag write seen at a negedge lands at the next posedge
  always @(negedge clk) begin
    if (tag_we) begin
      if (exp_q.size() == 0) begin
        chk(0, "R3 unexpected tag write", tag_idx, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(tag_idx) == e, "R3 index order", tag_idx, e);
        chk(clr_v && clr_m, "R3 both clear strobes", {clr_v, clr_m}, 3);
        chk(stall, "R4 stall during write", stall, 1);
      end
      v_arr[tag_idx] = ~clr_v & v_arr[tag_idx];
      m_arr[tag_idx] = ~clr_m & m_arr[tag_idx];
    end
  end

  task automatic run_sweep(input bit poke);
    int cnt;
    push_sweep();
    wr(1'b1);
    chk(stall == 1, "R1 stall after start", stall, 1);
    chk(cfg_rdata == 1, "R1 bit reads 1", cfg_rdata, 1);
    chk(tag_idx == 0, "R1 index starts 0", tag_idx, 0);
    cnt = 0;
    while (stall && cnt < N + 20) begin
      if (cnt == 5) chk(cfg_rdata == 1, "R5 bit held mid sweep", cfg_rdata, 1);
      if (poke && cnt == 100) begin cfg_we = 1; cfg_wdata = 1; end
      if (poke && cnt == 101) begin cfg_we = 0; cfg_wdata = 0; end
      cnt++;
      @(negedge clk);
    end
    chk(cnt == N, poke ? "R6 sweep length unchanged" : "R4 stall length", cnt, N);
    chk(cfg_rdata == 0, "R5 bit self-cleared", cfg_rdata, 0);
    chk(exp_q.size() == 0, "R3 all sets visited", exp_q.size(), 0);
    chk(v_arr == '0, "R8 valid bits cleared", $countones(v_arr), 0);
    chk(m_arr == '0, "R8 modified bits cleared", $countones(m_arr), 0);
    repeat (3) @(negedge clk);
    chk(stall == 0 && cfg_rdata == 0, "R5 stays idle", stall, 0);
  endtask

  initial begin
    v_arr = '1; m_arr = '1;
    repeat (3) @(negedge clk);
    chk(stall == 0 && cfg_rdata == 0, "R7 reset outputs", {stall, cfg_rdata}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(stall == 0 && cfg_rdata == 0, "R7 idle after reset", {stall, cfg_rdata}, 0);
    chk(v_arr == '1 && m_arr == '1, "R7 contents kept", $countones(v_arr), N);

    wr(1'b0);
    chk(stall == 0, "R2 write 0 no stall", stall, 0);
    chk(cfg_rdata == 0, "R2 write 0 reads 0", cfg_rdata, 0);
    chk(v_arr == '1, "R2 contents untouched", $countones(v_arr), N);

    run_sweep(1'b0);

    for (int i = 0; i < N; i++) begin v_arr[i] = i[0]; m_arr[i] = ~i[0]; end
    run_sweep(1'b1);

    for (int i = 0; i < N; i++) begin v_arr[i] = i[1]; m_arr[i] = 1'b1; end
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(stall == 0, "R7 no sweep after reset", stall, 0);
    chk($countones(v_arr) == N/2 && m_arr == '1, "R7 reset keeps contents",
        $countones(v_arr), N/2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule